// File: doc/BRIEF.md
# Multi-core interrupt distributor register file

The block collects interrupt requests from peripheral lines, per-core private lines and software, and works out for each core which sources should be forwarded to it. Software configures it through a simple register port. Each access carries a valid strobe, a write flag, a word address, write data and the index of the core that issues it. The core index selects that core's own copy of the banked state. Reads return data combinationally in the same cycle as the access.

Source IDs fall into three classes. IDs 0–15 are software-raised inter-core interrupts. IDs 16–31 are private lines, one set per core. IDs 32 and up are shared peripheral lines. Enable, pending and active state for IDs 0–31 is kept separately for every core, but each core reaches its copy at the same address. Every source has a trigger configuration, an 8-bit priority (a smaller value means more urgent) and, for shared sources, an 8-bit mask of destination cores. The block publishes one forwarded-pending vector per core and one summary request line per core.

A core acknowledges a source by writing its ID to the acknowledge word. This marks the source active for that core and consumes a latched edge. Writing the ID to the completion word clears the active state. A global enable gates all forwarding.

Top module: `irq_dist_top`

## Requirements
- R1: After synchronous reset, all enables, priorities, shared targets and configuration fields read 0, the global enable (word 0x000 bit 0) reads 0, and no core request line is high.
- R2: A read of word 0x001 returns NUM_SRC/32-1 in bits 4:0 and 0 elsewhere.
- R3: A write to word 0x040+k sets the enables of IDs 32k..32k+31 that have a 1 in the matching data bit. A write to word 0x060+k clears the enables with a 1 in the matching bit. Bits written 0 leave their enables unchanged. A read of either word returns the current enables.
- R4: The enable, pending and active state for IDs 0–31 is banked. The access's core index selects the copy, so one core's writes and pending state never show in another core's view or output.
- R5: Word 0x300+k holds the 2-bit field of ID 16k+j at bits 2j+1:2j. Field bit 1 set means rising-edge trigger; clear means level-high. The fields of IDs 0–15 always read 2'b10 and ignore writes.
- R6: Word 0x100+k holds the priority of ID 4k+b in byte b, and reads back what was written.
- R7: Word 0x200+k holds the core mask of ID 4k+b in byte b, where bit c selects core c. The words for IDs 0–31 ignore writes and read back, in every byte, only the bit of the reading core.
- R8: A write to word 0x3C0 with a core mask in bits 23:16 and an ID in bits 3:0 makes that ID pending on each selected core. Afterwards, word 0x3D0+ID read by a selected core returns the writer's core index in its low bits.
- R9: An edge-configured line latches pending on a 0-to-1 transition and holds it after the line falls. A level-configured line is pending while it is high and not active.
- R10: Writing an ID in bits 9:0 to word 0x3C1 marks that source active for the writing core (for IDs 32 and up, for all cores) and consumes its latched or software pending state. An active source is not forwarded. Writing the ID to word 0x3C2 clears the active state.
- R11: Bit c*NUM_SRC+id of core_pend is high exactly when the global enable is on and the source is enabled, pending, not active and aimed at core c. IDs 0–31 are aimed at their own core only. core_irq[c] is the OR of core c's bits.
- R12: While the global enable is 0, every core_pend and core_irq bit is 0. Writing 1 to it resumes forwarding of sources still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_core | input | $clog2(NUM_CORES) | Index of the core issuing the access |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address and core |
| ppi_in | input | NUM_CORES*16 | Private lines, bit 16*c+j is ID 16+j of core c |
| spi_in | input | NUM_SRC-32 | Shared lines, bit i is ID 32+i |
| core_pend | output | NUM_CORES*NUM_SRC | Forwarded pending vector per core |
| core_irq | output | NUM_CORES | Per-core request, OR of its forwarded vector |

## Verification
The checker watches, on every cycle, that the type word always reads the same count. It also checks that clearing all enables leaves the issuing core's banked enables empty one cycle later, that a software request lands in the pending state of a selected core, that disabling forwarding silences every core on the following cycle, and that the block comes out of reset quiet. Only the bench scenarios can show the rest. Those behaviours are: banking across cores, edge latches surviving the fall of their line, level sources dropping out while active and returning after completion, target and trigger fields steering sources to the right core, the read-only words ignoring writes, and the requester record of software interrupts.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 10'h000;
    localparam logic [ADDR_W-1:0] ADR_TYPE  = 10'h001;
    localparam logic [ADDR_W-1:0] ADR_ENSET = 10'h040;
    localparam logic [ADDR_W-1:0] ADR_ENCLR = 10'h060;
    localparam logic [ADDR_W-1:0] ADR_PRIO  = 10'h100;
    localparam logic [ADDR_W-1:0] ADR_TGT   = 10'h200;
    localparam logic [ADDR_W-1:0] ADR_CFG   = 10'h300;
    localparam logic [ADDR_W-1:0] ADR_SWI   = 10'h3C0;
    localparam logic [ADDR_W-1:0] ADR_ACK   = 10'h3C1;
    localparam logic [ADDR_W-1:0] ADR_EOI   = 10'h3C2;
    localparam logic [ADDR_W-1:0] ADR_SGSRC = 10'h3D0;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_TYPE, SEL_ENSET, SEL_ENCLR, SEL_PRIO,
        SEL_TGT, SEL_CFG, SEL_SWI, SEL_ACK, SEL_EOI, SEL_SGSRC
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [7:0] idx;
    } reg_dec_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] mask;
        logic [3:0] id;
    } swi_req_t;

    typedef struct packed {
        logic       valid;
        logic [9:0] id;
    } id_cmd_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a == ADR_CTRL)                 d.sel = SEL_CTRL;
        else if (a == ADR_TYPE)            d.sel = SEL_TYPE;
        else if (a[9:5] == 5'b00010) begin d.sel = SEL_ENSET; d.idx = {3'b0, a[4:0]}; end
        else if (a[9:5] == 5'b00011) begin d.sel = SEL_ENCLR; d.idx = {3'b0, a[4:0]}; end
        else if (a[9:8] == 2'b01)    begin d.sel = SEL_PRIO;  d.idx = a[7:0]; end
        else if (a[9:8] == 2'b10)    begin d.sel = SEL_TGT;   d.idx = a[7:0]; end
        else if (a[9:6] == 4'b1100)  begin d.sel = SEL_CFG;   d.idx = {2'b0, a[5:0]}; end
        else if (a == ADR_SWI)             d.sel = SEL_SWI;
        else if (a == ADR_ACK)             d.sel = SEL_ACK;
        else if (a == ADR_EOI)             d.sel = SEL_EOI;
        else if (a[9:4] == 6'h3D)    begin d.sel = SEL_SGSRC; d.idx = {4'b0, a[3:0]}; end
        return d;
    endfunction

    // Count field of the type word: sources/32 - 1, capped to the 5-bit field.
    function automatic logic [4:0] type_field(input int ns);
        int n;
        n = (ns > 1020 ? 1020 : ns) / 32 - 1;
        if (n > 31) n = 31;
        if (n < 0)  n = 0;
        return 5'(n);
    endfunction

endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NC = 4,
    parameter int NS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(NC)-1:0]         wr_core,
    input  reg_dec_t                      dec,
    input  logic [DATA_W-1:0]             wdata,
    output logic                          gen_en,
    output logic [NC-1:0][31:0]           en_bank,
    output logic [NS-33:0]                en_sh,
    output logic [NS-1:0][1:0]            cfg,
    output logic [NS-1:0][7:0]            prio,
    output logic [NS-33:0][7:0]           tgt_sh
);
    localparam int NSW = NS / 32;

    logic [NS-1:16][1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en  <= 1'b0;
            en_bank <= '0;
            en_sh   <= '0;
            cfg_q   <= '0;
            prio    <= '0;
            tgt_sh  <= '0;
        end else if (wr_en) begin
            case (dec.sel)
                SEL_CTRL: gen_en <= wdata[0];
                SEL_ENSET: begin
                    if (dec.idx == 8'd0) en_bank[wr_core] <= en_bank[wr_core] | wdata;
                    for (int w = 1; w < NSW; w++)
                        if (int'(dec.idx) == w)
                            en_sh[(w-1)*32 +: 32] <= en_sh[(w-1)*32 +: 32] | wdata;
                end
                SEL_ENCLR: begin
                    if (dec.idx == 8'd0) en_bank[wr_core] <= en_bank[wr_core] & ~wdata;
                    for (int w = 1; w < NSW; w++)
                        if (int'(dec.idx) == w)
                            en_sh[(w-1)*32 +: 32] <= en_sh[(w-1)*32 +: 32] & ~wdata;
                end
                SEL_PRIO: begin
                    for (int i = 0; i < NS; i++)
                        if (int'(dec.idx) == i / 4) prio[i] <= wdata[(i%4)*8 +: 8];
                end
                SEL_TGT: begin
                    for (int i = 32; i < NS; i++)
                        if (int'(dec.idx) == i / 4) tgt_sh[i-32] <= wdata[(i%4)*8 +: 8];
                end
                SEL_CFG: begin
                    for (int i = 16; i < NS; i++)
                        if (int'(dec.idx) == i / 16) cfg_q[i] <= wdata[(i%16)*2 +: 2];
                end
                default: ;
            endcase
        end
    end

    // Software-raised IDs are fixed to edge behaviour; the rest come from storage.
    generate
        for (genvar g = 0; g < NS; g++) begin : g_cfg
            if (g < 16) begin : g_fixed
                assign cfg[g] = 2'b10;
            end else begin : g_store
                assign cfg[g] = cfg_q[g];
            end
        end
    endgenerate

endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
    import irq_dist_pkg::*;
#(
    parameter int NC = 4,
    parameter int NS = 64
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NC-1:0][15:0]                ppi,
    input  logic [NS-33:0]                     spi,
    input  logic [NS-1:0][1:0]                 cfg,
    input  logic [$clog2(NC)-1:0]              wr_core,
    input  swi_req_t                           swi,
    input  id_cmd_t                            ack,
    input  id_cmd_t                            eoi,
    output logic [NC-1:0][31:0]                pend_bank,
    output logic [NC-1:0][31:0]                act_bank,
    output logic [NS-33:0]                     pend_sh,
    output logic [NS-33:0]                     act_sh,
    output logic [NC-1:0][15:0][$clog2(NC)-1:0] sgi_src
);
    localparam int NSH = NS - 32;
    localparam int SHW = $clog2(NSH);

    logic [NC-1:0][15:0] sgi_pend, ppi_prev, ppi_lat;
    logic [NSH-1:0]      spi_prev, spi_lat;
    logic [9:0]          ack_off, eoi_off;

    assign ack_off = ack.id - 10'd32;
    assign eoi_off = eoi.id - 10'd32;

    always_ff @(posedge clk) begin
        if (rst) begin
            sgi_pend <= '0;
            sgi_src  <= '0;
            ppi_prev <= '0;
            ppi_lat  <= '0;
            spi_prev <= '0;
            spi_lat  <= '0;
            act_bank <= '0;
            act_sh   <= '0;
        end else begin
            ppi_prev <= ppi;
            spi_prev <= spi;
            if (eoi.valid) begin
                if (eoi.id < 10'd32)               act_bank[wr_core][eoi.id[4:0]] <= 1'b0;
                else if (int'(eoi.id) < NS)        act_sh[eoi_off[SHW-1:0]]       <= 1'b0;
            end
            if (ack.valid) begin
                if (ack.id < 10'd16) begin
                    act_bank[wr_core][ack.id[4:0]] <= 1'b1;
                    sgi_pend[wr_core][ack.id[3:0]] <= 1'b0;
                end else if (ack.id < 10'd32) begin
                    act_bank[wr_core][ack.id[4:0]] <= 1'b1;
                    ppi_lat[wr_core][ack.id[3:0]]  <= 1'b0;
                end else if (int'(ack.id) < NS) begin
                    act_sh[ack_off[SHW-1:0]]  <= 1'b1;
                    spi_lat[ack_off[SHW-1:0]] <= 1'b0;
                end
            end
            // New events win over a same-cycle acknowledge.
            for (int c = 0; c < NC; c++)
                for (int j = 0; j < 16; j++)
                    if (cfg[16+j][1] && ppi[c][j] && !ppi_prev[c][j]) ppi_lat[c][j] <= 1'b1;
            for (int i = 0; i < NSH; i++)
                if (cfg[32+i][1] && spi[i] && !spi_prev[i]) spi_lat[i] <= 1'b1;
            if (swi.valid) begin
                for (int c = 0; c < NC; c++)
                    if (swi.mask[c]) begin
                        sgi_pend[c][swi.id] <= 1'b1;
                        sgi_src[c][swi.id]  <= wr_core;
                    end
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            pend_bank[c][15:0] = sgi_pend[c];
            for (int j = 0; j < 16; j++)
                pend_bank[c][16+j] = cfg[16+j][1] ? ppi_lat[c][j]
                                                  : (ppi[c][j] & ~act_bank[c][16+j]);
        end
        for (int i = 0; i < NSH; i++)
            pend_sh[i] = cfg[32+i][1] ? spi_lat[i] : (spi[i] & ~act_sh[i]);
    end

endmodule

// File: rtl/irq_dist_fwd.sv
module irq_dist_fwd #(
    parameter int NC = 4,
    parameter int NS = 64
) (
    input  logic                  gen_en,
    input  logic [NC-1:0][31:0]   en_bank,
    input  logic [NC-1:0][31:0]   pend_bank,
    input  logic [NC-1:0][31:0]   act_bank,
    input  logic [NS-33:0]        en_sh,
    input  logic [NS-33:0]        pend_sh,
    input  logic [NS-33:0]        act_sh,
    input  logic [NS-33:0][7:0]   tgt_sh,
    output logic [NC-1:0][NS-1:0] fwd,
    output logic [NC-1:0]         req
);
    generate
        for (genvar c = 0; c < NC; c++) begin : g_core
            for (genvar s = 0; s < NS; s++) begin : g_src
                if (s < 32) begin : g_local
                    assign fwd[c][s] = gen_en & en_bank[c][s] & pend_bank[c][s] & ~act_bank[c][s];
                end else begin : g_shared
                    assign fwd[c][s] = gen_en & en_sh[s-32] & tgt_sh[s-32][c]
                                     & pend_sh[s-32] & ~act_sh[s-32];
                end
            end
            assign req[c] = |fwd[c];
        end
    endgenerate

endmodule

// File: rtl/irq_dist_top.sv
module irq_dist_top
    import irq_dist_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SRC   = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_valid,
    input  logic                           reg_write,
    input  logic [$clog2(NUM_CORES)-1:0]   reg_core,
    input  logic [9:0]                     reg_addr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    input  logic [NUM_CORES*16-1:0]        ppi_in,
    input  logic [NUM_SRC-33:0]            spi_in,
    output logic [NUM_CORES*NUM_SRC-1:0]   core_pend,
    output logic [NUM_CORES-1:0]           core_irq
);
    localparam int NC  = NUM_CORES;
    localparam int NS  = NUM_SRC;
    localparam int NSW = NS / 32;
    localparam int CW  = $clog2(NC);

    reg_dec_t                         dec;
    logic                             wr_en;
    swi_req_t                         swi;
    id_cmd_t                          ack, eoi;
    logic                             gen_en;
    logic [NC-1:0][31:0]              en_bank, pend_bank, act_bank;
    logic [NS-33:0]                   en_sh, pend_sh, act_sh;
    logic [NS-1:0][1:0]               cfg;
    logic [NS-1:0][7:0]               prio;
    logic [NS-33:0][7:0]              tgt_sh;
    logic [NC-1:0][15:0]              ppi_2d;
    logic [NC-1:0][15:0][CW-1:0]      sgi_src;
    logic [NC-1:0][NS-1:0]            fwd;
    logic [7:0]                       own_mask;

    assign dec    = decode_addr(reg_addr);
    assign wr_en  = reg_valid & reg_write;
    assign ppi_2d = ppi_in;

    assign swi.valid = wr_en && (dec.sel == SEL_SWI);
    assign swi.mask  = reg_wdata[23:16];
    assign swi.id    = reg_wdata[3:0];
    assign ack.valid = wr_en && (dec.sel == SEL_ACK);
    assign ack.id    = reg_wdata[9:0];
    assign eoi.valid = wr_en && (dec.sel == SEL_EOI);
    assign eoi.id    = reg_wdata[9:0];

    irq_dist_regs #(.NC(NC), .NS(NS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_core(reg_core), .dec(dec),
        .wdata(reg_wdata), .gen_en(gen_en), .en_bank(en_bank), .en_sh(en_sh),
        .cfg(cfg), .prio(prio), .tgt_sh(tgt_sh)
    );

    irq_dist_state #(.NC(NC), .NS(NS)) u_state (
        .clk(clk), .rst(rst), .ppi(ppi_2d), .spi(spi_in), .cfg(cfg),
        .wr_core(reg_core), .swi(swi), .ack(ack), .eoi(eoi),
        .pend_bank(pend_bank), .act_bank(act_bank), .pend_sh(pend_sh),
        .act_sh(act_sh), .sgi_src(sgi_src)
    );

    irq_dist_fwd #(.NC(NC), .NS(NS)) u_fwd (
        .gen_en(gen_en), .en_bank(en_bank), .pend_bank(pend_bank),
        .act_bank(act_bank), .en_sh(en_sh), .pend_sh(pend_sh), .act_sh(act_sh),
        .tgt_sh(tgt_sh), .fwd(fwd), .req(core_irq)
    );

    assign core_pend = fwd;
    assign own_mask  = 8'(1 << reg_core);

    always_comb begin
        reg_rdata = '0;
        case (dec.sel)
            SEL_CTRL: reg_rdata[0]   = gen_en;
            SEL_TYPE: reg_rdata[4:0] = type_field(NS);
            SEL_ENSET, SEL_ENCLR: begin
                if (dec.idx == 8'd0) reg_rdata = en_bank[reg_core];
                for (int w = 1; w < NSW; w++)
                    if (int'(dec.idx) == w) reg_rdata = en_sh[(w-1)*32 +: 32];
            end
            SEL_PRIO: begin
                for (int i = 0; i < NS; i++)
                    if (int'(dec.idx) == i / 4) reg_rdata[(i%4)*8 +: 8] = prio[i];
            end
            SEL_TGT: begin
                for (int i = 0; i < 32; i++)
                    if (int'(dec.idx) == i / 4) reg_rdata[(i%4)*8 +: 8] = own_mask;
                for (int i = 32; i < NS; i++)
                    if (int'(dec.idx) == i / 4) reg_rdata[(i%4)*8 +: 8] = tgt_sh[i-32];
            end
            SEL_CFG: begin
                for (int i = 0; i < NS; i++)
                    if (int'(dec.idx) == i / 16) reg_rdata[(i%16)*2 +: 2] = cfg[i];
            end
            SEL_SGSRC: reg_rdata[CW-1:0] = sgi_src[reg_core][dec.idx[3:0]];
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
    import irq_dist_pkg::*;
#(
    parameter int NC = 4,
    parameter int NS = 64
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_valid,
    input logic                   reg_write,
    input logic [$clog2(NC)-1:0]  reg_core,
    input logic [9:0]             reg_addr,
    input logic [31:0]            reg_wdata,
    input logic [31:0]            reg_rdata,
    input logic [NC-1:0]          core_irq,
    input logic                   gen_en,
    input logic [NC-1:0][31:0]    en_bank,
    input logic [NC-1:0][31:0]    pend_bank
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (core_irq == '0 && !gen_en)); // R1

    AST_TYPE_READ: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_write && reg_addr == ADR_TYPE)
            |-> reg_rdata == {27'b0, 5'(NS/32 - 1)}); // R2

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_write && reg_addr == ADR_ENCLR && reg_wdata == 32'hFFFF_FFFF)
            |=> en_bank[$past(reg_core)] == 32'h0); // R3

    AST_SWI_LANDS: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_write && reg_addr == ADR_SWI && reg_wdata[16])
            |=> pend_bank[0][$past(reg_wdata[3:0])]); // R8

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_write && reg_addr == ADR_CTRL && !reg_wdata[0])
            |=> core_irq == '0); // R12

endmodule

bind irq_dist_top irq_dist_chk #(.NC(NUM_CORES), .NS(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_core(reg_core), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_irq(core_irq), .gen_en(gen_en),
    .en_bank(en_bank), .pend_bank(pend_bank)
);

// File: tb/irq_dist_top_tb.sv
`timescale 1ns/1ps
module irq_dist_top_tb;
    localparam int NC = 4;
    localparam int NS = 64;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                reg_valid = 1'b0;
    logic                reg_write = 1'b0;
    logic [1:0]          reg_core = '0;
    logic [9:0]          reg_addr = '0;
    logic [31:0]         reg_wdata = '0;
    logic [31:0]         reg_rdata;
    logic [NC*16-1:0]    ppi_in = '0;
    logic [NS-33:0]      spi_in = '0;
    logic [NC*NS-1:0]    core_pend;
    logic [NC-1:0]       core_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit obs_req = 1'b0;

    typedef struct {
        int          kind;   // 0 read data, 1 core vector, 2 request lines
        int          core;
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    irq_dist_top #(.NUM_CORES(NC), .NUM_SRC(NS)) u_dut (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_core(reg_core), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ppi_in(ppi_in), .spi_in(spi_in),
        .core_pend(core_pend), .core_irq(core_irq)
    );

    // Monitor: pops the expected item and compares in the middle of the cycle.
    always @(negedge clk) begin
        if (!rst && (obs_req || (reg_valid && !reg_write))) begin
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: result with no expected item");
            end else begin
                item_t it;
                logic [63:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0: act = {32'b0, reg_rdata};
                    1: act = core_pend[it.core*NS +: NS];
                    default: act = {60'b0, core_irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input int c, input logic [9:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_valid = 1'b1; reg_write = 1'b1; reg_core = 2'(c); reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input int c, input logic [9:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = 0; it.core = c; it.exp = {32'b0, e}; it.tag = tag;
        @(posedge clk); #1;
        sbq.push_back(it);
        reg_valid = 1'b1; reg_write = 1'b0; reg_core = 2'(c); reg_addr = a;
        @(posedge clk); #1;
        reg_valid = 1'b0;
    endtask

    task automatic obs(input int kind, input int c, input logic [63:0] e, input string tag);
        item_t it;
        it.kind = kind; it.core = c; it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        sbq.push_back(it);
        obs_req = 1'b1;
        @(posedge clk); #1;
        obs_req = 1'b0;
    endtask

    task automatic pulse_spi(input int i);
        @(posedge clk); #1; spi_in[i] = 1'b1;
        @(posedge clk); #1; spi_in[i] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, R2 type word
        rd(0, 10'h000, 32'h0, "R1 ctrl");
        rd(0, 10'h040, 32'h0, "R1 banked enables");
        rd(1, 10'h108, 32'h0, "R1 priority");
        rd(0, 10'h208, 32'h0, "R1 target");
        rd(0, 10'h302, 32'h0, "R1 config");
        obs(2, 0, 64'h0, "R1 request lines");
        rd(3, 10'h001, 32'h1, "R2 type count");

        // R3 set/clear views, R4 banking
        wr(0, 10'h040, 32'h0000_0003);
        rd(0, 10'h040, 32'h3, "R3 set view");
        rd(1, 10'h040, 32'h0, "R4 other core enables");
        wr(0, 10'h060, 32'h0000_0001);
        rd(0, 10'h060, 32'h2, "R3 clear view");
        wr(0, 10'h040, 32'h0);
        rd(0, 10'h040, 32'h2, "R3 zero bits ignored");
        wr(2, 10'h041, 32'h0000_000F);
        rd(0, 10'h061, 32'hF, "R3 shared word");

        // R6 priority
        wr(1, 10'h109, 32'hA0B1_C2D3);
        rd(3, 10'h109, 32'hA0B1_C2D3, "R6 priority bytes");
        rd(0, 10'h108, 32'h0, "R6 neighbour word");

        // R7 targets
        wr(0, 10'h208, 32'h0804_0201);
        rd(1, 10'h208, 32'h0804_0201, "R7 shared targets");
        wr(0, 10'h200, 32'hFFFF_FFFF);
        rd(2, 10'h200, 32'h0404_0404, "R7 local targets read-only");

        // R5 configuration
        wr(0, 10'h300, 32'hFFFF_FFFF);
        rd(0, 10'h300, 32'hAAAA_AAAA, "R5 fixed software fields");
        wr(0, 10'h302, 32'h0000_0002);
        rd(1, 10'h302, 32'h2, "R5 shared fields");

        wr(0, 10'h000, 32'h1);
        rd(0, 10'h000, 32'h1, "R12 global enable");

        // R9 edge on ID 32 (target core 0)
        pulse_spi(0);
        obs(1, 0, 64'h1 << 32, "R9 edge latched");
        obs(1, 1, 64'h0, "R11 not aimed at core 1");
        // R10 acknowledge and completion
        wr(0, 10'h3C1, 32'd32);
        obs(1, 0, 64'h0, "R10 active not forwarded");
        pulse_spi(0);
        obs(1, 0, 64'h0, "R10 new edge held while active");
        wr(0, 10'h3C2, 32'd32);
        obs(1, 0, 64'h1 << 32, "R10 completion re-forwards");
        wr(0, 10'h3C1, 32'd32);
        wr(0, 10'h3C2, 32'd32);
        obs(1, 0, 64'h0, "R10 latch consumed");

        // R9 level on ID 33 (target core 1)
        @(posedge clk); #1 spi_in[1] = 1'b1;
        obs(1, 1, 64'h1 << 33, "R9 level pending");
        obs(2, 0, 64'h2, "R11 request lines");
        wr(0, 10'h000, 32'h0);
        obs(2, 0, 64'h0, "R12 forwarding off");
        wr(0, 10'h000, 32'h1);
        obs(2, 0, 64'h2, "R12 forwarding resumes");
        wr(1, 10'h3C1, 32'd33);
        obs(1, 1, 64'h0, "R10 level active");
        wr(1, 10'h3C2, 32'd33);
        obs(1, 1, 64'h1 << 33, "R10 level after completion");
        @(posedge clk); #1 spi_in[1] = 1'b0;
        obs(1, 1, 64'h0, "R9 level drops");

        // R11 ID 36 enabled but aimed at no core
        wr(0, 10'h041, 32'h0000_0010);
        @(posedge clk); #1 spi_in[4] = 1'b1;
        obs(2, 0, 64'h0, "R11 empty target mask");
        @(posedge clk); #1 spi_in[4] = 1'b0;

        // R8 software interrupt ID 5 from core 2 to cores 0 and 1
        wr(0, 10'h040, 32'h0000_0020);
        wr(2, 10'h3C0, 32'h0003_0005);
        obs(1, 0, 64'h1 << 5, "R8 software pending core 0");
        obs(1, 1, 64'h0, "R4 core 1 not enabled");
        rd(1, 10'h3D5, 32'h2, "R8 requester seen by core 1");
        rd(0, 10'h3D5, 32'h2, "R8 requester seen by core 0");
        wr(1, 10'h040, 32'h0000_0020);
        obs(1, 1, 64'h1 << 5, "R4 core 1 own enable");
        wr(0, 10'h3C1, 32'd5);
        obs(1, 0, 64'h0, "R10 software acknowledged");
        obs(1, 1, 64'h1 << 5, "R4 banked pending kept");

        // R9/R4 private line ID 20 on core 3
        wr(3, 10'h040, 32'h0010_0000);
        @(posedge clk); #1 ppi_in[3*16+4] = 1'b1;
        obs(1, 3, 64'h1 << 20, "R9 private level");
        obs(1, 0, 64'h0, "R4 private line of other core");
        @(posedge clk); #1 ppi_in[3*16+4] = 1'b0;

        // R1 reset mid-run
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd(0, 10'h000, 32'h0, "R1 ctrl after reset");
        rd(0, 10'h041, 32'h0, "R1 shared enables after reset");
        obs(2, 0, 64'h0, "R1 lines after reset");

        repeat (2) @(posedge clk);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", sbq.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule